// File: doc/BRIEF.md
# SPI Master Register Bank

This block is the software-facing side of an SPI master controller. A word-addressed bus reaches ten 32-bit registers: a receive port, a transmit port, control, configuration, interrupt enable, DMA settings, status, period, test and a message slot. Transmit words go into a 64-word FIFO that an exchange engine drains. Received words come back from the engine into a second 64-word FIFO that software reads out through the receive port.

The status flags follow FIFO occupancy on every cycle. One level interrupt is raised when any flag is set and its enable bit is also set. Writes to control select a channel and drive its active-low chip select. Control writes and transmit writes also raise start requests toward the engine. A start request is held while the engine reports busy. While the controller is disabled the register file is write-locked, and clearing the enable bit acts as a soft reset that keeps the control word that was written.

Top module: `spi_ctl_regs`

## Requirements
- R1: The register index is busAddr[11:2]. The indices are 0 receive port, 1 transmit port, 2 control, 3 config, 4 interrupt enable, 5 DMA, 6 status, 7 period, 8 test, 9 message. An access whose low two address bits are nonzero, or whose index is 10 or more, writes nothing and reads 0.
- R2: While control bit 0 (enable) is 0, writes to every register except control have no effect, and a read of the receive port returns 0 without removing a word.
- R3: A control write with bit 0 clear stores the written control word. It clears config, interrupt enable, DMA, period and test. It clears the overflow and complete flags so that status reads 0x00000003, empties both FIFOs and drives all chip selects high.
- R4: Status bits are live: bit0 TX FIFO empty, bit1 TX FIFO holds at most half its depth, bit2 TX FIFO full, bit3 RX FIFO not empty, bit4 RX FIFO full.
- R5: irq is 1 exactly when some status bit and the matching interrupt-enable bit are both 1.
- R6: Status bit5 (receive overflow) is set when the engine delivers a word while the RX FIFO is full, and that word is dropped. Bit6 (transfer complete) is set by xferDone. Writing 1 to bit5 or bit6 clears it, and writes to the other status bits are ignored.
- R7: While enabled, a read of the receive port returns the oldest RX word and removes it, or returns 0xDEADBEEF when the RX FIFO is empty. Reads of the transmit port and the message slot return 0.
- R8: A transmit-port write while the TX FIFO holds 64 words is discarded. Otherwise the word is queued, and a start is requested if the selected channel is master and control bit 3 (single-shot start) is set.
- R9: A control write with enable set, where the mode bit control[4+sel] of the channel sel = control[19:18] is 1, drives csN[sel] low and every other chip select high. Otherwise the chip selects do not change.
- R10: Such a master control write requests a start if bit 3 goes from 0 to 1 while the TX FIFO is non-empty, or if bit 2 (exchange) goes from 0 to 1 while the new bit 3 is 0. A control write for a non-master channel requests nothing.
- R11: A pending start appears as a one-cycle engStart pulse in the first cycle engBusy is 0, and it waits as long as engBusy is 1.
- R12: txAvail and txWord present the oldest TX word, and txTake removes it. xferDone clears control bit 2 when the TX FIFO is empty.
- R13: After hardware reset, control reads 0, status reads 0x00000003, irq is 0 and all chip selects are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous hardware reset |
| busAddr | input | 12 | Byte address of the access |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after busRd |
| irq | output | 1 | Level interrupt |
| csN | output | 4 | Active-low chip selects |
| engStart | output | 1 | Start pulse to the exchange engine |
| engBusy | input | 1 | Engine busy, holds pending starts |
| txAvail | output | 1 | TX FIFO has a word |
| txWord | output | 32 | Oldest TX word |
| txTake | input | 1 | Engine removes the oldest TX word |
| rxPush | input | 1 | Engine delivers a received word |
| rxWord | input | 32 | Received word |
| xferDone | input | 1 | Engine reports a finished transfer |

## Verification
On every cycle, the assertions check that at most one chip select is low and that a soft reset leaves both FIFOs empty with all selects high. They also check that the locked registers hold while the controller is disabled, that FIFO occupancy never passes its depth, that a full-FIFO push changes nothing, that the overflow flag follows a dropped receive word, and that a start pulse lasts one cycle. The directed scenarios cover the behaviour that depends on sequences and data: the order of words popped from each FIFO, the empty marker, write-one-to-clear of the two sticky flags, each start trigger and its stall under busy, and the register values after a soft reset.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;

  localparam int NUM_REGS = 10;

  localparam logic [3:0] REG_RX     = 4'd0;
  localparam logic [3:0] REG_TX     = 4'd1;
  localparam logic [3:0] REG_CTRL   = 4'd2;
  localparam logic [3:0] REG_CFG    = 4'd3;
  localparam logic [3:0] REG_IRQEN  = 4'd4;
  localparam logic [3:0] REG_DMA    = 4'd5;
  localparam logic [3:0] REG_STAT   = 4'd6;
  localparam logic [3:0] REG_PERIOD = 4'd7;
  localparam logic [3:0] REG_TEST   = 4'd8;
  localparam logic [3:0] REG_MSG    = 4'd9;

  // control word fields
  localparam int CTL_EN       = 0;
  localparam int CTL_XCH      = 2;
  localparam int CTL_SMC      = 3;
  localparam int CTL_MODE_LSB = 4;
  localparam int CTL_SEL_LSB  = 18;

  // status bit positions for the sticky flags
  localparam int STAT_RO = 5;
  localparam int STAT_TC = 6;

  localparam logic [31:0] EMPTY_MARK = 32'hDEAD_BEEF;

  typedef struct packed {
    logic       wrCtrl;
    logic       wrCfg;
    logic       wrIrqEn;
    logic       wrDma;
    logic       wrStat;
    logic       wrPeriod;
    logic       wrTest;
    logic       wrTx;
    logic       rdRx;
    logic       rdHit;
    logic [3:0] rdSel;
  } regStrobe_t;

endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         flush,
  input  logic                         push,
  input  logic [WIDTH-1:0]             din,
  input  logic                         pop,
  output logic [WIDTH-1:0]             dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         empty,
  output logic                         full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic             doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = mem[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));

  assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop && !flush) |=> $stable(count));

endmodule

// File: rtl/spi_regs_decode.sv
module spi_regs_decode
  import spi_regs_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              ctrlEn,
  output regStrobe_t        strb
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             inRange;
  logic             wrOk;

  assign idx     = busAddr[ADDR_W-1:2];
  assign inRange = (busAddr[1:0] == 2'b00) && (idx < IDX_W'(NUM_REGS));
  // while disabled only the control register accepts writes
  assign wrOk    = busWr && inRange && (ctrlEn || idx == IDX_W'(REG_CTRL));

  always_comb begin
    strb          = '0;
    strb.wrCtrl   = wrOk && (idx == IDX_W'(REG_CTRL));
    strb.wrCfg    = wrOk && (idx == IDX_W'(REG_CFG));
    strb.wrIrqEn  = wrOk && (idx == IDX_W'(REG_IRQEN));
    strb.wrDma    = wrOk && (idx == IDX_W'(REG_DMA));
    strb.wrStat   = wrOk && (idx == IDX_W'(REG_STAT));
    strb.wrPeriod = wrOk && (idx == IDX_W'(REG_PERIOD));
    strb.wrTest   = wrOk && (idx == IDX_W'(REG_TEST));
    strb.wrTx     = wrOk && (idx == IDX_W'(REG_TX));
    strb.rdHit    = busRd && inRange;
    strb.rdRx     = busRd && inRange && ctrlEn && (idx == IDX_W'(REG_RX));
    strb.rdSel    = idx[3:0];
  end

endmodule

// File: rtl/spi_regs_dpath.sv
module spi_regs_dpath
  import spi_regs_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int NUM_CS     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [31:0]       busWdata,
  input  logic              busRd,
  output logic              ctrlEn,
  output logic [31:0]       busRdata,
  output logic              irq,
  output logic [NUM_CS-1:0] csN,
  output logic              engStart,
  input  logic              engBusy,
  output logic              txAvail,
  output logic [31:0]       txWord,
  input  logic              txTake,
  input  logic              rxPush,
  input  logic [31:0]       rxWord,
  input  logic              xferDone
);
  localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam int CW    = $clog2(FIFO_DEPTH+1);

  logic [31:0] ctrlReg, cfgReg, irqEnReg, dmaReg, periodReg, testReg;
  logic        roBit, tcBit, startPend;
  logic        softRst;

  logic [CW-1:0] txCount, rxCount;
  logic          txEmpty, txFull, rxEmpty, rxFull;
  logic [31:0]   rxHead;
  logic [31:0]   statusWord;
  logic [31:0]   rdMux;

  logic [SEL_W-1:0] newSel, curSel;
  logic             newMaster, curMaster;
  logic             ctrlKick, txKick;

  assign ctrlEn  = ctrlReg[CTL_EN];
  assign softRst = strb.wrCtrl && !busWdata[CTL_EN];

  spi_word_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) txFifo (
    .clk(clk), .rstN(rstN), .flush(softRst),
    .push(strb.wrTx), .din(busWdata),
    .pop(txTake), .dout(txWord),
    .count(txCount), .empty(txEmpty), .full(txFull)
  );

  spi_word_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) rxFifo (
    .clk(clk), .rstN(rstN), .flush(softRst),
    .push(rxPush), .din(rxWord),
    .pop(strb.rdRx), .dout(rxHead),
    .count(rxCount), .empty(rxEmpty), .full(rxFull)
  );

  assign txAvail    = !txEmpty;
  assign statusWord = 32'({tcBit, roBit, rxFull, !rxEmpty, txFull,
                           (txCount <= CW'(FIFO_DEPTH/2)), txEmpty});
  assign irq        = |(statusWord & irqEnReg);

  // channel decode for the incoming and the stored control word
  assign newSel    = busWdata[CTL_SEL_LSB +: SEL_W];
  assign newMaster = busWdata[CTL_MODE_LSB + int'(newSel)];
  assign curSel    = ctrlReg[CTL_SEL_LSB +: SEL_W];
  assign curMaster = ctrlReg[CTL_MODE_LSB + int'(curSel)];

  assign ctrlKick = strb.wrCtrl && busWdata[CTL_EN] && newMaster &&
                    ((busWdata[CTL_SMC] && !ctrlReg[CTL_SMC] && !txEmpty) ||
                     (busWdata[CTL_XCH] && !ctrlReg[CTL_XCH] && !busWdata[CTL_SMC]));
  assign txKick   = strb.wrTx && !txFull && curMaster && ctrlReg[CTL_SMC];

  assign engStart = startPend && !engBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (strb.wrCtrl) begin
      ctrlReg <= busWdata;
    end else if (xferDone && txEmpty) begin
      ctrlReg[CTL_XCH] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg    <= '0;
      irqEnReg  <= '0;
      dmaReg    <= '0;
      periodReg <= '0;
      testReg   <= '0;
    end else if (softRst) begin
      cfgReg    <= '0;
      irqEnReg  <= '0;
      dmaReg    <= '0;
      periodReg <= '0;
      testReg   <= '0;
    end else begin
      if (strb.wrCfg)    cfgReg    <= busWdata;
      if (strb.wrIrqEn)  irqEnReg  <= busWdata;
      if (strb.wrDma)    dmaReg    <= busWdata;
      if (strb.wrPeriod) periodReg <= busWdata;
      if (strb.wrTest)   testReg   <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      roBit <= 1'b0;
      tcBit <= 1'b0;
    end else if (softRst) begin
      roBit <= 1'b0;
      tcBit <= 1'b0;
    end else begin
      if (rxPush && rxFull)                      roBit <= 1'b1;
      else if (strb.wrStat && busWdata[STAT_RO]) roBit <= 1'b0;
      if (xferDone)                              tcBit <= 1'b1;
      else if (strb.wrStat && busWdata[STAT_TC]) tcBit <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csN <= '1;
    end else if (softRst) begin
      csN <= '1;
    end else if (strb.wrCtrl && newMaster) begin
      for (int i = 0; i < NUM_CS; i++) csN[i] <= (SEL_W'(i) != newSel);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   startPend <= 1'b0;
    else if (softRst)            startPend <= 1'b0;
    else if (ctrlKick || txKick) startPend <= 1'b1;
    else if (engStart)           startPend <= 1'b0;
  end

  always_comb begin
    rdMux = '0;
    if (strb.rdHit) begin
      case (strb.rdSel)
        REG_RX:     rdMux = ctrlEn ? (rxEmpty ? EMPTY_MARK : rxHead) : '0;
        REG_TX:     rdMux = '0;
        REG_CTRL:   rdMux = ctrlReg;
        REG_CFG:    rdMux = cfgReg;
        REG_IRQEN:  rdMux = irqEnReg;
        REG_DMA:    rdMux = dmaReg;
        REG_STAT:   rdMux = statusWord;
        REG_PERIOD: rdMux = periodReg;
        REG_TEST:   rdMux = testReg;
        REG_MSG:    rdMux = '0;
        default:    rdMux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      busRdata <= '0;
    else if (busRd) busRdata <= rdMux;
  end

  assert_cs_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  assert_soft_reset_R3: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> ((&csN) && txCount == '0 && rxCount == '0 && !startPend));

  assert_locked_regs_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlEn && !strb.wrCtrl) |=> ($stable(cfgReg) && $stable(irqEnReg) &&
                                  $stable(dmaReg) && $stable(testReg)));

  assert_overflow_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && rxFull && !softRst) |=> roBit);

  assert_start_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    (engStart && !ctrlKick && !txKick) |=> !engStart);

  assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (irqEnReg != '0));

endmodule

// File: rtl/spi_ctl_regs.sv
module spi_ctl_regs
  import spi_regs_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int FIFO_DEPTH = 64,
  parameter int NUM_CS     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irq,
  output logic [NUM_CS-1:0] csN,
  output logic              engStart,
  input  logic              engBusy,
  output logic              txAvail,
  output logic [31:0]       txWord,
  input  logic              txTake,
  input  logic              rxPush,
  input  logic [31:0]       rxWord,
  input  logic              xferDone
);
  regStrobe_t strb;
  logic       ctrlEn;

  spi_regs_decode #(.ADDR_W(ADDR_W)) decodeU (
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .ctrlEn(ctrlEn), .strb(strb)
  );

  spi_regs_dpath #(.FIFO_DEPTH(FIFO_DEPTH), .NUM_CS(NUM_CS)) dpathU (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata), .busRd(busRd),
    .ctrlEn(ctrlEn), .busRdata(busRdata), .irq(irq), .csN(csN),
    .engStart(engStart), .engBusy(engBusy),
    .txAvail(txAvail), .txWord(txWord), .txTake(txTake),
    .rxPush(rxPush), .rxWord(rxWord), .xferDone(xferDone)
  );

endmodule

// File: tb/spi_ctl_regs_test.sv
module spi_ctl_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;
  logic [3:0]  csN;
  logic        engStart, engBusy = 1'b0;
  logic        txAvail, txTake = 1'b0;
  logic [31:0] txWord;
  logic        rxPush = 1'b0, xferDone = 1'b0;
  logic [31:0] rxWord = '0;

  int testsRun = 0;
  int testsFailed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_ctl_regs uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq), .csN(csN),
    .engStart(engStart), .engBusy(engBusy), .txAvail(txAvail), .txWord(txWord),
    .txTake(txTake), .rxPush(rxPush), .rxWord(rxWord), .xferDone(xferDone)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic wrAddr(input logic [11:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic wrReg(input int idx, input logic [31:0] d);
    wrAddr(12'(idx * 4), d);
  endtask

  task automatic rdAddr(input logic [11:0] a, output logic [31:0] d);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  task automatic rdReg(input int idx, output logic [31:0] d);
    rdAddr(12'(idx * 4), d);
  endtask

  task automatic pushRx(input logic [31:0] w);
    rxWord = w; rxPush = 1'b1;
    @(negedge clk);
    rxPush = 1'b0;
  endtask

  task automatic takeTx();
    txTake = 1'b1;
    @(negedge clk);
    txTake = 1'b0;
  endtask

  task automatic pulseDone();
    xferDone = 1'b1;
    @(negedge clk);
    xferDone = 1'b0;
  endtask

  // register indices and control words
  localparam int IX_RX = 0, IX_TX = 1, IX_CTRL = 2, IX_CFG = 3, IX_IRQEN = 4;
  localparam int IX_DMA = 5, IX_STAT = 6, IX_PERIOD = 7, IX_TEST = 8, IX_MSG = 9;
  localparam logic [31:0] CTL_CH2 = 32'h0008_0041; // en, ch2 master, sel 2
  localparam logic [31:0] CTL_CH1 = 32'h0004_0041; // en, ch2 master, sel 1

  task automatic testResetState();
    logic [31:0] d;
    doReset();
    rdReg(IX_STAT, d); check("R13 status after reset", d, 32'h3);
    rdReg(IX_CTRL, d); check("R13 control after reset", d, 32'h0);
    check("R13 csN after reset", 32'(csN), 32'hF);
    check("R13 irq after reset", 32'(irq), 32'h0);
    check("R12 txAvail after reset", 32'(txAvail), 32'h0);
  endtask

  task automatic testDisabledGate();
    logic [31:0] d;
    doReset();
    wrReg(IX_CFG, 32'h55);
    pushRx(32'hA5);
    rdReg(IX_RX, d); check("R2 rx read while disabled", d, 32'h0);
    wrReg(IX_CTRL, 32'h1);
    rdReg(IX_CFG, d); check("R2 config write dropped while disabled", d, 32'h0);
    rdReg(IX_RX, d); check("R2 R7 rx word kept and popped", d, 32'hA5);
    rdReg(IX_RX, d); check("R7 empty marker", d, 32'hDEADBEEF);
    rdReg(IX_TX, d); check("R7 tx port reads 0", d, 32'h0);
    rdReg(IX_MSG, d); check("R7 message reads 0", d, 32'h0);
  endtask

  task automatic testAddressing();
    logic [31:0] d;
    doReset();
    wrReg(IX_CTRL, 32'h1);
    wrReg(IX_CFG, 32'h1234);
    wrReg(12, 32'hFFFF);
    rdReg(12, d); check("R1 out of range read", d, 32'h0);
    wrAddr(12'(IX_CFG * 4 + 1), 32'hBEEF);
    rdReg(IX_CFG, d); check("R1 config kept after bad writes", d, 32'h1234);
    rdAddr(12'(IX_CFG * 4 + 2), d); check("R1 misaligned read", d, 32'h0);
    wrReg(IX_DMA, 32'h5); wrReg(IX_PERIOD, 32'h9); wrReg(IX_TEST, 32'h3);
    rdReg(IX_DMA, d); check("R1 dma register", d, 32'h5);
    rdReg(IX_PERIOD, d); check("R1 period register", d, 32'h9);
  endtask

  task automatic testFifoStatus();
    logic [31:0] d;
    doReset();
    wrReg(IX_CTRL, 32'h1);
    wrReg(IX_IRQEN, 32'h1);
    check("R5 irq on tx empty", 32'(irq), 32'h1);
    wrReg(IX_TX, 32'd0);
    check("R5 irq drops", 32'(irq), 32'h0);
    rdReg(IX_STAT, d); check("R4 status one tx word", d, 32'h2);
    for (int i = 1; i <= 64; i++) wrReg(IX_TX, 32'(i));
    rdReg(IX_STAT, d); check("R4 status tx full", d, 32'h4);
    check("R12 tx head", txWord, 32'd0);
    for (int i = 0; i < 63; i++) takeTx();
    check("R8 last queued word", txWord, 32'd63);
    takeTx();
    check("R8 65th word dropped", 32'(txAvail), 32'h0);
    for (int i = 0; i < 65; i++) pushRx(32'(100 + i));
    rdReg(IX_STAT, d); check("R4 R6 rx full with overflow", d, 32'h3B);
    wrReg(IX_STAT, 32'hFFFF_FFFF);
    rdReg(IX_STAT, d); check("R6 overflow cleared, live bits kept", d, 32'h1B);
    rdReg(IX_RX, d); check("R7 oldest rx word", d, 32'd100);
    rdReg(IX_STAT, d); check("R4 rx no longer full", d, 32'h0B);
    wrReg(IX_IRQEN, 32'h20);
    check("R5 irq off when flag clear", 32'(irq), 32'h0);
  endtask

  task automatic testSelectAndStart();
    logic [31:0] d;
    doReset();
    wrReg(IX_CTRL, CTL_CH2);
    check("R9 csN channel 2 low", 32'(csN), 32'hB);
    check("R10 no start without trigger", 32'(engStart), 32'h0);
    wrReg(IX_TX, 32'h11);
    check("R8 no start when single-shot clear", 32'(engStart), 32'h0);
    wrReg(IX_CTRL, CTL_CH2 | 32'h4);
    check("R10 exchange rise starts", 32'(engStart), 32'h1);
    @(negedge clk);
    check("R11 start is one cycle", 32'(engStart), 32'h0);
    check("R12 tx head to engine", txWord, 32'h11);
    wrReg(IX_CTRL, CTL_CH2 | 32'h8);
    check("R10 single-shot rise starts", 32'(engStart), 32'h1);
    @(negedge clk);
    engBusy = 1'b1;
    wrReg(IX_TX, 32'h22);
    check("R11 start held while busy", 32'(engStart), 32'h0);
    @(negedge clk);
    check("R11 still held", 32'(engStart), 32'h0);
    engBusy = 1'b0;
    #1;
    check("R8 R11 tx write start released", 32'(engStart), 32'h1);
    @(negedge clk);
    check("R11 released start one cycle", 32'(engStart), 32'h0);
    wrReg(IX_CTRL, CTL_CH1);
    wrReg(IX_CTRL, CTL_CH1 | 32'h4);
    check("R10 non-master no start", 32'(engStart), 32'h0);
    check("R9 csN unchanged for non-master", 32'(csN), 32'hB);
    takeTx(); takeTx();
    pulseDone();
    rdReg(IX_STAT, d); check("R6 transfer complete set", d, 32'h43);
    rdReg(IX_CTRL, d); check("R12 exchange bit cleared", d, CTL_CH1);
    wrReg(IX_STAT, 32'h40);
    rdReg(IX_STAT, d); check("R6 complete cleared", d, 32'h3);
  endtask

  task automatic testSoftReset();
    logic [31:0] d;
    doReset();
    wrReg(IX_CTRL, CTL_CH2);
    wrReg(IX_CFG, 32'h77); wrReg(IX_IRQEN, 32'h1); wrReg(IX_DMA, 32'h5);
    wrReg(IX_PERIOD, 32'h9); wrReg(IX_TEST, 32'h3);
    wrReg(IX_TX, 32'h1);
    pushRx(32'h9);
    check("R9 csN before soft reset", 32'(csN), 32'hB);
    wrReg(IX_CTRL, 32'h0008_0040);
    check("R3 csN all high", 32'(csN), 32'hF);
    check("R3 tx fifo empty", 32'(txAvail), 32'h0);
    check("R3 irq low", 32'(irq), 32'h0);
    rdReg(IX_CTRL, d); check("R3 control kept", d, 32'h0008_0040);
    rdReg(IX_CFG, d); check("R3 config cleared", d, 32'h0);
    rdReg(IX_IRQEN, d); check("R3 irq enable cleared", d, 32'h0);
    rdReg(IX_TEST, d); check("R3 test cleared", d, 32'h0);
    rdReg(IX_STAT, d); check("R3 status value", d, 32'h3);
    wrReg(IX_CTRL, 32'h1);
    rdReg(IX_RX, d); check("R3 rx fifo emptied", d, 32'hDEADBEEF);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    testResetState();
    testDisabledGate();
    testAddressing();
    testFifoStatus();
    testSelectAndStart();
    testSoftReset();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule